// File: doc/BRIEF.md
# Memory Fence Completion Tracker

This unit sits between an instruction pipeline and its data memory port and makes fence instructions effective. Each data memory operation sent to memory raises a one-cycle issue strobe, and each response that returns raises a one-cycle completion strobe. The unit keeps a single up/down count of operations still in flight. A fence instruction raises a request strobe. The fence is then held pending until the in-flight count has drained to zero, and the unit answers with a one-cycle done pulse.

While any fence is pending, the issue-allow output is low. The pipeline must not send further data operations until the fence has retired. Several fence requests may be queued. They retire strictly in the order they arrived, one per cycle, once the count is zero. Overflow of either internal counter, and a completion that arrives with nothing in flight, set sticky error flags that only reset clears.

Top module: `fence_tracker`

## Requirements
- R1: An issue strobe without a completion strobe raises the outstanding count (`outstanding_o`) by one in the following cycle.
- R2: A completion strobe without an issue strobe lowers the outstanding count by one in the following cycle.
- R3: When an issue strobe and a completion strobe arrive in the same cycle, the outstanding count is unchanged.
- R4: A pending fence retires with a one-cycle `fence_done_o` pulse in the first cycle in which the outstanding count reads zero. A fence requested while the count is zero retires in the cycle after its request.
- R5: `issue_ok_o` is low in every cycle in which at least one fence is pending, and from the cycle after any fence request; it is high otherwise.
- R6: Fence requests queue up to 2^FQ_W-1 deep. Queued fences retire in arrival order, one done pulse per cycle, while the count is zero. A request that arrives in the cycle of a done pulse is queued behind the retiring fence.
- R7: An issue strobe without a completion strobe at the maximum count (2^CNT_W-1) leaves the count at that maximum and sets `ovf_err_o`.
- R8: A completion strobe without an issue strobe at count zero leaves the count at zero and sets `udf_err_o`.
- R9: A fence request that arrives with the fence queue full, and no fence retiring in that cycle, is dropped and sets `ovf_err_o`.
- R10: After the synchronous active-high reset, the count is zero, no fence is pending, `issue_ok_o` is 1, and `fence_done_o`, `ovf_err_o` and `udf_err_o` are 0. Error flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_issue_i | input | 1 | One-cycle strobe per data operation sent to memory |
| op_cmpl_i | input | 1 | One-cycle strobe per data operation response |
| fence_req_i | input | 1 | One-cycle strobe per fence instruction |
| fence_done_o | output | 1 | One-cycle pulse when the oldest pending fence retires |
| issue_ok_o | output | 1 | High when the pipeline may issue data operations |
| outstanding_o | output | CNT_W | Number of data operations in flight |
| ovf_err_o | output | 1 | Sticky: operation count or fence queue overflow |
| udf_err_o | output | 1 | Sticky: completion with nothing in flight |

## Verification
The assertions take for granted that the pipeline honours `issue_ok_o`: no issue strobe appears while it is low. The count and queue properties also assume a single strobe per event. The stimulus draws issue strobes only when the bench's model shows no fence pending. It draws completions only when the model count is above zero, and fence requests only while the model queue has room. The error and overflow cases are driven in separate, directed segments, each preceded by a reset, so that the sticky flags do not mask the checks that follow.

// File: rtl/fence_trk_pkg.sv
package fence_trk_pkg;

    // Direction of the outstanding-count update for one cycle
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_UP   = 2'd1,
        CNT_DOWN = 2'd2
    } cnt_op_e;

    // Error events raised by the counters in one cycle
    typedef struct packed {
        logic ovf;
        logic udf;
    } err_flags_t;

    localparam int ERR_FLAG_N = $bits(err_flags_t);

    // An issue paired with a completion leaves the count alone
    function automatic cnt_op_e decode_op(input logic iss, input logic cmp);
        cnt_op_e r;
        if (iss && !cmp)      r = CNT_UP;
        else if (cmp && !iss) r = CNT_DOWN;
        else                  r = CNT_HOLD;
        return r;
    endfunction

endpackage

// File: rtl/op_counter.sv
module op_counter
    import fence_trk_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_i,
    input  logic             cmpl_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_o,
    output err_flags_t       err_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    cnt_op_e          op;

    assign op = decode_op(issue_i, cmpl_i);

    always_comb begin
        cnt_d     = cnt_q;
        err_o.ovf = 1'b0;
        err_o.udf = 1'b0;
        case (op)
            CNT_UP: begin
                if (cnt_q == CNT_MAX) err_o.ovf = 1'b1;
                else                  cnt_d = cnt_q + CNT_ONE;
            end
            CNT_DOWN: begin
                if (cnt_q == '0) err_o.udf = 1'b1;
                else             cnt_d = cnt_q - CNT_ONE;
            end
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
    assign zero_o  = (cnt_q == '0);

    // R1
    a_r1_count_up: assert property (@(posedge clk) disable iff (rst)
        (issue_i && !cmpl_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_ONE);
    // R2
    a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
        (cmpl_i && !issue_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_ONE);
    // R3
    a_r3_pair_holds: assert property (@(posedge clk) disable iff (rst)
        (issue_i && cmpl_i) |=> $stable(cnt_q));
    // R7
    a_r7_saturate_top: assert property (@(posedge clk) disable iff (rst)
        (issue_i && !cmpl_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

endmodule

// File: rtl/fence_queue.sv
module fence_queue #(
    parameter int FQ_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_i,
    input  logic            cnt_zero_i,
    output logic            done_o,
    output logic            busy_o,
    output logic            drop_o,
    output logic [FQ_W-1:0] pending_o
);
    localparam logic [FQ_W-1:0] FQ_MAX = '1;

    logic [FQ_W-1:0] pend_q;
    logic [FQ_W-1:0] after_pop;
    logic [FQ_W-1:0] pend_d;
    logic            accept;

    // Oldest fence retires once nothing earlier is in flight
    assign done_o    = (pend_q != '0) && cnt_zero_i;
    assign after_pop = pend_q - FQ_W'(done_o);
    assign accept    = req_i && (after_pop != FQ_MAX);
    assign drop_o    = req_i && !accept;
    assign pend_d    = after_pop + FQ_W'(accept);

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign busy_o    = (pend_q != '0);
    assign pending_o = pend_q;

    // R6
    a_r6_one_retire: assert property (@(posedge clk) disable iff (rst)
        (done_o && !req_i) |=> pend_q == $past(pend_q) - FQ_W'(1));
    // R6
    a_r6_retire_and_queue: assert property (@(posedge clk) disable iff (rst)
        (done_o && req_i) |=> $stable(pend_q));
    // R9
    a_r9_full_drop: assert property (@(posedge clk) disable iff (rst)
        (req_i && pend_q == FQ_MAX && !cnt_zero_i) |=> pend_q == FQ_MAX);

endmodule

// File: rtl/err_sticky.sv
module err_sticky
    import fence_trk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  err_flags_t evt_i,
    output err_flags_t flag_o
);
    logic [ERR_FLAG_N-1:0] evt_bits;
    logic [ERR_FLAG_N-1:0] hold_q;

    assign evt_bits = evt_i;

    for (genvar g = 0; g < ERR_FLAG_N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)              hold_q[g] <= 1'b0;
            else if (evt_bits[g]) hold_q[g] <= 1'b1;
        end
        // R10
        a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
            hold_q[g] |=> hold_q[g]);
    end

    assign flag_o = hold_q;

endmodule

// File: rtl/fence_tracker.sv
module fence_tracker
    import fence_trk_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int FQ_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_issue_i,
    input  logic             op_cmpl_i,
    input  logic             fence_req_i,
    output logic             fence_done_o,
    output logic             issue_ok_o,
    output logic [CNT_W-1:0] outstanding_o,
    output logic             ovf_err_o,
    output logic             udf_err_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic            cnt_zero;
    logic            fq_busy;
    logic            fq_drop;
    logic [FQ_W-1:0] fq_pending;
    err_flags_t      cnt_err;
    err_flags_t      all_err;
    err_flags_t      err_hold;

    op_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .issue_i (op_issue_i),
        .cmpl_i  (op_cmpl_i),
        .count_o (outstanding_o),
        .zero_o  (cnt_zero),
        .err_o   (cnt_err)
    );

    fence_queue #(.FQ_W(FQ_W)) u_fq (
        .clk        (clk),
        .rst        (rst),
        .req_i      (fence_req_i),
        .cnt_zero_i (cnt_zero),
        .done_o     (fence_done_o),
        .busy_o     (fq_busy),
        .drop_o     (fq_drop),
        .pending_o  (fq_pending)
    );

    always_comb begin
        all_err     = cnt_err;
        all_err.ovf = cnt_err.ovf | fq_drop;
    end

    err_sticky u_err (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (all_err),
        .flag_o (err_hold)
    );

    assign issue_ok_o = !fq_busy;
    assign ovf_err_o  = err_hold.ovf;
    assign udf_err_o  = err_hold.udf;

    // Input contract: the pipeline honours the issue-allow output
    a_r5_issue_honoured: assert property (@(posedge clk) disable iff (rst)
        !issue_ok_o |-> !op_issue_i);
    // R5
    a_r5_block_after_req: assert property (@(posedge clk) disable iff (rst)
        fence_req_i |=> !issue_ok_o);
    // R4
    a_r4_done_at_zero: assert property (@(posedge clk) disable iff (rst)
        fence_done_o |-> outstanding_o == '0);
    // R4
    a_r4_retire_first_zero: assert property (@(posedge clk) disable iff (rst)
        (!issue_ok_o && outstanding_o == '0) |-> fence_done_o);
    // R7
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (op_issue_i && !op_cmpl_i && outstanding_o == CNT_MAX) |=> ovf_err_o);
    // R8
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (op_cmpl_i && !op_issue_i && outstanding_o == '0) |=> udf_err_o && outstanding_o == '0);
    // R6
    a_r6_pending_bound: assert property (@(posedge clk) disable iff (rst)
        (fq_pending != '0) |-> !issue_ok_o);

endmodule

// File: tb/fence_tracker_bench.sv
module fence_tracker_bench;
    localparam int CNT_W = 4;
    localparam int FQ_W  = 2;
    localparam int CMAX  = (1 << CNT_W) - 1;
    localparam int FMAX  = (1 << FQ_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_issue = 1'b0, op_cmpl = 1'b0, fence_req = 1'b0;
    logic fence_done, issue_ok, ovf_err, udf_err;
    logic [CNT_W-1:0] outstanding;

    int vecs = 0;
    int errs = 0;
    int m_cnt = 0, m_pend = 0;
    bit m_ovf = 0, m_udf = 0;

    always #10 clk = ~clk;

    fence_tracker #(.CNT_W(CNT_W), .FQ_W(FQ_W)) u_fence_tracker (
        .clk(clk), .rst(rst),
        .op_issue_i(op_issue), .op_cmpl_i(op_cmpl), .fence_req_i(fence_req),
        .fence_done_o(fence_done), .issue_ok_o(issue_ok),
        .outstanding_o(outstanding), .ovf_err_o(ovf_err), .udf_err_o(udf_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R1/R2/R3 outstanding", int'(outstanding), m_cnt);
        chk("R4/R6 fence_done", int'(fence_done), int'(m_pend > 0 && m_cnt == 0));
        chk("R5 issue_ok", int'(issue_ok), int'(m_pend == 0));
        chk("R7/R9 ovf_err", int'(ovf_err), int'(m_ovf));
        chk("R8 udf_err", int'(udf_err), int'(m_udf));
    endtask

    // Compare at the falling edge, then drive and advance the model
    task automatic step(input bit iss, input bit cmp, input bit frq);
        int done, tmp;
        @(negedge clk);
        compare();
        op_issue  = iss;
        op_cmpl   = cmp;
        fence_req = frq;
        done = (m_pend > 0 && m_cnt == 0) ? 1 : 0;
        if (iss && !cmp) begin
            if (m_cnt == CMAX) m_ovf = 1; else m_cnt++;
        end else if (cmp && !iss) begin
            if (m_cnt == 0) m_udf = 1; else m_cnt--;
        end
        tmp = m_pend - done;
        if (frq) begin
            if (tmp == FMAX) m_ovf = 1; else tmp++;
        end
        m_pend = tmp;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_issue = 0; op_cmpl = 0; fence_req = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt = 0; m_pend = 0; m_ovf = 0; m_udf = 0;
    endtask

    initial begin
        do_reset();
        // R10 reset state
        step(0, 0, 0);
        // R1: three issues
        step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
        // R2: one completion, R3: paired strobes
        step(0, 1, 0); step(1, 1, 0); step(0, 0, 0);
        // R4/R5: fence waits for two in flight
        step(0, 0, 1); step(0, 0, 0); step(0, 1, 0); step(0, 0, 0);
        step(0, 1, 0); step(0, 0, 0); step(0, 0, 0);
        // R4: fence at count zero retires next cycle
        step(0, 0, 1); step(0, 0, 0); step(0, 0, 0);
        // R6: three queued fences behind one op, then request during retire
        step(1, 0, 0); step(0, 0, 1); step(0, 0, 1); step(0, 0, 1);
        step(0, 1, 0); step(0, 0, 0); step(0, 0, 1); step(0, 0, 0);
        step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
        // Random legal traffic
        for (int i = 0; i < 600; i++) begin
            bit iss, cmp, frq;
            iss = (m_pend == 0) && (m_cnt < CMAX) && ($urandom % 2 == 0);
            cmp = (m_cnt > 0) && ($urandom % 3 == 0);
            frq = (m_pend < FMAX - 1) && ($urandom % 9 == 0);
            step(iss, cmp, frq);
        end
        // R8: underflow
        do_reset();
        step(0, 1, 0); step(0, 0, 0); step(1, 0, 0); step(0, 0, 0);
        // R7: operation count overflow
        do_reset();
        for (int i = 0; i < CMAX; i++) step(1, 0, 0);
        step(1, 0, 0); step(0, 0, 0); step(0, 1, 0); step(0, 0, 0);
        // R9: fence queue overflow
        do_reset();
        step(1, 0, 0);
        for (int i = 0; i < FMAX; i++) step(0, 0, 1);
        step(0, 0, 1); step(0, 0, 0); step(0, 1, 0);
        for (int i = 0; i < FMAX + 2; i++) step(0, 0, 0);
        // R10: reset clears sticky flags
        do_reset();
        step(0, 0, 0);
        @(negedge clk);
        compare();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule